// File: doc/BRIEF.md
# Codec Register Command Engine

This block sits on the controller side of a frame-based audio codec link. It lets a host read and write the registers of an external codec. The host first loads a 16-bit value for the command-data slot. It then loads a register index and a read flag for the command-address slot. Loading the address is the commit point. At the next frame strobe, the engine places the command into the outgoing frame and raises a per-slot tag that marks the slot as carrying valid content. The codec's answer arrives in later frames. The engine captures the returned address word and data word separately, and raises a valid flag for each.

Serial bit clocking and the tag slot are reduced to a one-cycle frame strobe, per-slot tag bits and parallel 20-bit slot words. The engine also runs the link reset sequence: the active-low link reset is held for a fixed number of clocks, and the engine then waits a number of frames before any traffic is allowed. A select field picks one of four codecs; select values of four and above block transmission. Comparing the returned index against the requested one, retrying and timing out are left to the host, which polls the busy and valid flags.

Top module: `ac_link_cmd_engine`

## Requirements
- R1: The outgoing command-address word carries the read flag at bit 19 and the 7-bit register index at bits 18:12, with bits 11:0 zero.
- R2: The outgoing command-data word carries the 16-bit value at bits 19:4, with bits 3:0 zero.
- R3: Loading the data word alone sends nothing. Loading the address word queues the command, and the command goes out at the next frame strobe with txTag1 high for that frame. txTag2 is high only when the data slot goes out with it. Both tags return low at the next frame that carries no command.
- R4: txBusy1 and txBusy2 rise when their slot is loaded and stay high until the frame in which that slot is sent. Loading a slot again while it is busy replaces the pending content, and only one command is sent.
- R5: A slot whose transmit enable (slot1TxEn or slot2TxEn) is low is not sent, and its busy flag stays high. Slot 2 is sent only together with slot 1.
- R6: txCodec carries codecSel[1:0] for the frame that holds the command. A codecSel of 4 or more sends nothing and leaves the command pending.
- R7: At a frame strobe with rxTag1 (rxTag2) high, the engine captures the slot word and sets rxValid1 (rxValid2). rxIdx shows bits 18:12 of the captured address word, and rxVal shows bits 19:4 of the captured data word.
- R8: hostRdAck1 (hostRdAck2) clears rxValid1 (rxValid2). A capture in the same cycle wins, and the other slot's flag is untouched.
- R9: linkRstN is low for RST_CYCLES clocks after reset or after linkResetReq. linkReady then rises at the WAKE_FRAMES-th frame strobe. While not ready, nothing is sent and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrData | input | 1 | Load hostVal into the data slot |
| hostWrAddr | input | 1 | Load hostRead/hostIdx into the address slot and commit |
| hostRead | input | 1 | Read flag for the command |
| hostIdx | input | 7 | Codec register index |
| hostVal | input | 16 | Write value |
| hostRdAck1 | input | 1 | Host has taken the returned address |
| hostRdAck2 | input | 1 | Host has taken the returned data |
| slot1TxEn | input | 1 | Transmit enable, address slot |
| slot2TxEn | input | 1 | Transmit enable, data slot |
| codecSel | input | 3 | Codec select, values 0..3 valid |
| linkResetReq | input | 1 | Restart the link reset sequence |
| txBusy1 | output | 1 | Address slot pending |
| txBusy2 | output | 1 | Data slot pending |
| rxValid1 | output | 1 | Returned address captured |
| rxValid2 | output | 1 | Returned data captured |
| rxIdx | output | 7 | Returned register index |
| rxVal | output | 16 | Returned register value |
| linkRstN | output | 1 | Active-low link reset to the codec |
| linkReady | output | 1 | Link may carry traffic |
| frameStb | input | 1 | One-cycle frame start |
| txTag1 | output | 1 | Address slot valid in current frame |
| txTag2 | output | 1 | Data slot valid in current frame |
| txSlot1 | output | 20 | Outgoing address slot word |
| txSlot2 | output | 20 | Outgoing data slot word |
| txCodec | output | 2 | Codec addressed in current frame |
| rxTag1 | input | 1 | Incoming address slot valid |
| rxTag2 | input | 1 | Incoming data slot valid |
| rxSlot1In | input | 20 | Incoming address slot word |
| rxSlot2In | input | 20 | Incoming data slot word |

## Verification
The properties check, on every cycle, the rules about when things may change:
- tags and busy flags change only at frame strobes;
- slot 2 never goes out without slot 1;
- no tag appears while the link is not ready or the codec select is out of range;
- valid flags rise only on a frame.

The bench scenarios are the only place the following are shown:
- the bit placement of index, read flag and value;
- that an overwrite yields exactly one command;
- that a disabled slot keeps its pending content;
- that the reset low time is exact;
- how a read acknowledge and a capture in the same cycle resolve.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;
  localparam int SLOT_W   = 20;
  localparam int IDX_W    = 7;
  localparam int VAL_W    = 16;
  localparam int ADDR_LSB = 12;
  localparam int DATA_LSB = 4;
  localparam int CODEC_W  = 2;

  typedef struct packed {
    logic loadData;
    logic loadAddr;
    logic send1;
    logic send2;
    logic cap1;
    logic cap2;
    logic frame;
  } linkStb_t;
endpackage

// File: rtl/ac_link_ctrl.sv
module ac_link_ctrl
  import ac_link_pkg::*;
#(
  parameter int RST_CYCLES  = 500,
  parameter int WAKE_FRAMES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrData,
  input  logic               hostWrAddr,
  input  logic               hostRdAck1,
  input  logic               hostRdAck2,
  input  logic               slot1TxEn,
  input  logic               slot2TxEn,
  input  logic [CODEC_W:0]   codecSel,
  input  logic               linkResetReq,
  input  logic               frameStb,
  input  logic               rxTag1,
  input  logic               rxTag2,
  output linkStb_t           stb,
  output logic               txBusy1,
  output logic               txBusy2,
  output logic               rxValid1,
  output logic               rxValid2,
  output logic               linkRstN,
  output logic               linkReady
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam int FW = $clog2(WAKE_FRAMES + 1);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYCLES - 1);
  localparam logic [FW-1:0] WAKE_LAST = FW'(WAKE_FRAMES - 1);

  typedef enum logic [1:0] {PH_HOLD, PH_WAKE, PH_READY} phase_t;
  phase_t phase;
  logic [CW-1:0] holdCnt;
  logic [FW-1:0] wakeCnt;
  logic codecOk;

  assign codecOk   = ~codecSel[CODEC_W];
  assign linkRstN  = (phase != PH_HOLD);
  assign linkReady = (phase == PH_READY);

  always_comb begin
    stb          = '0;
    stb.loadData = hostWrData;
    stb.loadAddr = hostWrAddr;
    stb.frame    = frameStb;
    stb.send1    = frameStb & linkReady & txBusy1 & slot1TxEn & codecOk;
    stb.send2    = stb.send1 & txBusy2 & slot2TxEn;
    stb.cap1     = frameStb & linkReady & rxTag1;
    stb.cap2     = frameStb & linkReady & rxTag2;
  end

  always_ff @(posedge clk) begin
    if (!rstN || linkResetReq) begin
      phase   <= PH_HOLD;
      holdCnt <= '0;
      wakeCnt <= '0;
    end else begin
      case (phase)
        PH_HOLD: begin
          if (holdCnt == RST_LAST) begin
            phase   <= PH_WAKE;
            holdCnt <= '0;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        PH_WAKE: begin
          if (frameStb) begin
            if (wakeCnt == WAKE_LAST) phase <= PH_READY;
            wakeCnt <= wakeCnt + 1'b1;
          end
        end
        default: phase <= PH_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy1  <= 1'b0;
      txBusy2  <= 1'b0;
      rxValid1 <= 1'b0;
      rxValid2 <= 1'b0;
    end else begin
      if (hostWrAddr)     txBusy1 <= 1'b1;
      else if (stb.send1) txBusy1 <= 1'b0;
      if (hostWrData)     txBusy2 <= 1'b1;
      else if (stb.send2) txBusy2 <= 1'b0;
      if (stb.cap1)       rxValid1 <= 1'b1;
      else if (hostRdAck1) rxValid1 <= 1'b0;
      if (stb.cap2)       rxValid2 <= 1'b1;
      else if (hostRdAck2) rxValid2 <= 1'b0;
    end
  end
endmodule

// File: rtl/ac_link_dp.sv
module ac_link_dp
  import ac_link_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  linkStb_t           stb,
  input  logic               hostRead,
  input  logic [IDX_W-1:0]   hostIdx,
  input  logic [VAL_W-1:0]   hostVal,
  input  logic [CODEC_W:0]   codecSel,
  input  logic [SLOT_W-1:0]  rxSlot1In,
  input  logic [SLOT_W-1:0]  rxSlot2In,
  output logic               txTag1,
  output logic               txTag2,
  output logic [SLOT_W-1:0]  txSlot1,
  output logic [SLOT_W-1:0]  txSlot2,
  output logic [CODEC_W-1:0] txCodec,
  output logic [IDX_W-1:0]   rxIdx,
  output logic [VAL_W-1:0]   rxVal
);
  logic               readReg;
  logic [IDX_W-1:0]   idxReg;
  logic [VAL_W-1:0]   valReg;
  logic [SLOT_W-1:0]  addrWord, dataWord, rxWord1, rxWord2;

  assign addrWord = {readReg, idxReg, {ADDR_LSB{1'b0}}};
  assign dataWord = {valReg, {DATA_LSB{1'b0}}};
  assign rxIdx    = rxWord1[ADDR_LSB +: IDX_W];
  assign rxVal    = rxWord2[DATA_LSB +: VAL_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readReg <= 1'b0;
      idxReg  <= '0;
      valReg  <= '0;
      rxWord1 <= '0;
      rxWord2 <= '0;
      txTag1  <= 1'b0;
      txTag2  <= 1'b0;
      txSlot1 <= '0;
      txSlot2 <= '0;
      txCodec <= '0;
    end else begin
      if (stb.loadAddr) begin
        readReg <= hostRead;
        idxReg  <= hostIdx;
      end
      if (stb.loadData) valReg <= hostVal;
      if (stb.cap1) rxWord1 <= rxSlot1In;
      if (stb.cap2) rxWord2 <= rxSlot2In;
      if (stb.frame) begin
        txTag1  <= stb.send1;
        txTag2  <= stb.send2;
        txSlot1 <= stb.send1 ? addrWord : '0;
        txSlot2 <= stb.send2 ? dataWord : '0;
        if (stb.send1) txCodec <= codecSel[CODEC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ac_link_cmd_engine.sv
module ac_link_cmd_engine
  import ac_link_pkg::*;
#(
  parameter int RST_CYCLES  = 500,
  parameter int WAKE_FRAMES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrData,
  input  logic               hostWrAddr,
  input  logic               hostRead,
  input  logic [IDX_W-1:0]   hostIdx,
  input  logic [VAL_W-1:0]   hostVal,
  input  logic               hostRdAck1,
  input  logic               hostRdAck2,
  input  logic               slot1TxEn,
  input  logic               slot2TxEn,
  input  logic [CODEC_W:0]   codecSel,
  input  logic               linkResetReq,
  output logic               txBusy1,
  output logic               txBusy2,
  output logic               rxValid1,
  output logic               rxValid2,
  output logic [IDX_W-1:0]   rxIdx,
  output logic [VAL_W-1:0]   rxVal,
  output logic               linkRstN,
  output logic               linkReady,
  input  logic               frameStb,
  output logic               txTag1,
  output logic               txTag2,
  output logic [SLOT_W-1:0]  txSlot1,
  output logic [SLOT_W-1:0]  txSlot2,
  output logic [CODEC_W-1:0] txCodec,
  input  logic               rxTag1,
  input  logic               rxTag2,
  input  logic [SLOT_W-1:0]  rxSlot1In,
  input  logic [SLOT_W-1:0]  rxSlot2In
);
  linkStb_t stb;

  ac_link_ctrl #(.RST_CYCLES(RST_CYCLES), .WAKE_FRAMES(WAKE_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrData(hostWrData), .hostWrAddr(hostWrAddr),
    .hostRdAck1(hostRdAck1), .hostRdAck2(hostRdAck2),
    .slot1TxEn(slot1TxEn), .slot2TxEn(slot2TxEn), .codecSel(codecSel),
    .linkResetReq(linkResetReq), .frameStb(frameStb),
    .rxTag1(rxTag1), .rxTag2(rxTag2), .stb(stb),
    .txBusy1(txBusy1), .txBusy2(txBusy2), .rxValid1(rxValid1), .rxValid2(rxValid2),
    .linkRstN(linkRstN), .linkReady(linkReady)
  );

  ac_link_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostRead(hostRead), .hostIdx(hostIdx),
    .hostVal(hostVal), .codecSel(codecSel), .rxSlot1In(rxSlot1In),
    .rxSlot2In(rxSlot2In), .txTag1(txTag1), .txTag2(txTag2),
    .txSlot1(txSlot1), .txSlot2(txSlot2), .txCodec(txCodec),
    .rxIdx(rxIdx), .rxVal(rxVal)
  );
endmodule

// File: rtl/ac_link_cmd_sva.sv
module ac_link_cmd_sva
  import ac_link_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             frameStb,
  input logic             hostWrAddr,
  input logic             hostWrData,
  input logic [CODEC_W:0] codecSel,
  input logic             txBusy1,
  input logic             txBusy2,
  input logic             txTag1,
  input logic             txTag2,
  input logic             rxValid1,
  input logic             rxValid2,
  input logic             linkRstN,
  input logic             linkReady
);
  // R3: data slot never goes out alone
  p_tag2_with_tag1_r3: assert property (@(posedge clk) disable iff (!rstN)
    txTag2 |-> txTag1);

  // R3: tags move only at a frame boundary
  p_tag_frame_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    !frameStb |=> $stable(txTag1) && $stable(txTag2));

  // R4: a pending address slot is dropped only at a frame
  p_busy1_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy1 && !frameStb) |=> txBusy1);

  // R4: a pending data slot is dropped only at a frame
  p_busy2_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy2 && !frameStb) |=> txBusy2);

  // R6: an out-of-range select leaves the frame empty
  p_bad_codec_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && codecSel[CODEC_W]) |=> !txTag1);

  // R7: valid flags rise only on a frame strobe
  p_valid_on_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxValid1) || $rose(rxValid2)) |-> $past(frameStb));

  // R9: no traffic while the link is not ready
  p_no_tx_unready_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && !linkReady) |=> !txTag1);

  // R9: ready never overlaps link reset
  p_ready_not_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    !linkRstN |-> !linkReady);
endmodule

bind ac_link_cmd_engine ac_link_cmd_sva u_sva (
  .clk(clk), .rstN(rstN), .frameStb(frameStb), .hostWrAddr(hostWrAddr),
  .hostWrData(hostWrData), .codecSel(codecSel), .txBusy1(txBusy1),
  .txBusy2(txBusy2), .txTag1(txTag1), .txTag2(txTag2), .rxValid1(rxValid1),
  .rxValid2(rxValid2), .linkRstN(linkRstN), .linkReady(linkReady)
);

// File: tb/test_ac_link_cmd_engine.sv
module test_ac_link_cmd_engine;
  localparam int RST_CYC = 500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrData = 0, hostWrAddr = 0, hostRead = 0;
  logic [6:0] hostIdx = '0;
  logic [15:0] hostVal = '0;
  logic hostRdAck1 = 0, hostRdAck2 = 0;
  logic slot1TxEn = 1, slot2TxEn = 1;
  logic [2:0] codecSel = 3'd0;
  logic linkResetReq = 0;
  logic txBusy1, txBusy2, rxValid1, rxValid2;
  logic [6:0] rxIdx;
  logic [15:0] rxVal;
  logic linkRstN, linkReady;
  logic frameStb = 0;
  logic txTag1, txTag2;
  logic [19:0] txSlot1, txSlot2;
  logic [1:0] txCodec;
  logic rxTag1 = 0, rxTag2 = 0;
  logic [19:0] rxSlot1In = '0, rxSlot2In = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ac_link_cmd_engine i_ac_link_cmd_engine (.*);

  // {isRead, idx, val, expSlot1, expSlot2}
  typedef struct packed {
    logic        rd;
    logic [6:0]  idx;
    logic [15:0] val;
    logic [19:0] exp1;
    logic [19:0] exp2;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{1'b1, 7'h26, 16'h0000, 20'hA6000, 20'h00000},
    '{1'b0, 7'h02, 16'h801E, 20'h02000, 20'h801E0},
    '{1'b0, 7'h7F, 16'hFFFF, 20'h7F000, 20'hFFFF0},
    '{1'b1, 7'h00, 16'h0000, 20'h80000, 20'h00000},
    '{1'b0, 7'h2C, 16'hBB80, 20'h2C000, 20'hBB800}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic frame();
    frameStb = 1; cyc(); frameStb = 0;
  endtask

  task automatic wrData(input logic [15:0] v);
    hostVal = v; hostWrData = 1; cyc(); hostWrData = 0;
  endtask

  task automatic wrAddr(input logic r, input logic [6:0] i);
    hostRead = r; hostIdx = i; hostWrAddr = 1; cyc(); hostWrAddr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lowCnt;
    repeat (3) cyc();
    check("R9 reset busy1", txBusy1, 0);
    check("R9 reset valid", {rxValid1, rxValid2}, 0);
    check("R9 reset link", {linkRstN, linkReady, txTag1}, 0);
    rstN = 1;
    lowCnt = 0;
    while (!linkRstN && lowCnt < 2000) begin lowCnt++; cyc(); end
    check("R9 reset low time", lowCnt, RST_CYC);

    // not ready yet: command and incoming slot ignored
    wrAddr(1'b1, 7'h11);
    rxTag1 = 1; rxSlot1In = 20'h11000;
    frame();
    rxTag1 = 0;
    check("R9 no tx before ready", txTag1, 0);
    check("R9 no capture before ready", rxValid1, 0);
    check("R9 busy kept", txBusy1, 1);
    frame();
    check("R9 ready after wake frames", linkReady, 1);
    frame();
    check("R9 pending sent once ready", {txTag1, txSlot1}, {1'b1, 20'h91000});
    frame();
    check("R3 tag drops on empty frame", {txTag1, txTag2}, 0);

    // data alone is not sent
    wrData(16'h5555);
    check("R4 busy2 set", txBusy2, 1);
    frame();
    check("R3 data alone not sent", {txTag1, txTag2}, 0);
    check("R3 data stays pending", txBusy2, 1);
    wrAddr(1'b0, 7'h05);
    frame();
    check("R3 commit sends both", {txTag1, txTag2, txSlot2}, {2'b11, 20'h55550});

    foreach (VECS[k]) begin
      if (!VECS[k].rd) wrData(VECS[k].val);
      wrAddr(VECS[k].rd, VECS[k].idx);
      check("R4 busy1 after commit", txBusy1, 1);
      frame();
      check("R1 slot1 word", {txTag1, txSlot1}, {1'b1, VECS[k].exp1});
      check("R3 slot2 tag", txTag2, !VECS[k].rd);
      check("R2 slot2 word", txSlot2, VECS[k].exp2);
      check("R4 busy cleared", {txBusy1, txBusy2}, 0);
    end

    // overwrite while busy
    wrAddr(1'b1, 7'h10);
    wrAddr(1'b1, 7'h20);
    frame();
    check("R4 latest overwrite sent", txSlot1, 20'hA0000);
    frame();
    check("R4 single command", txTag1, 0);

    // slot enables
    slot2TxEn = 0;
    wrData(16'hABCD); wrAddr(1'b0, 7'h03);
    frame();
    check("R5 slot2 disabled", {txTag1, txTag2}, 2'b10);
    check("R5 slot2 still busy", txBusy2, 1);
    slot2TxEn = 1; slot1TxEn = 0;
    wrAddr(1'b0, 7'h04);
    frame();
    check("R5 slot1 disabled", {txTag1, txBusy1}, 2'b01);
    slot1TxEn = 1;
    frame();
    check("R5 resumed with old data", {txTag1, txTag2, txSlot2}, {2'b11, 20'hABCD0});

    // codec select
    codecSel = 3'd2; wrAddr(1'b1, 7'h7C);
    frame();
    check("R6 codec id", {txTag1, txCodec}, {1'b1, 2'd2});
    codecSel = 3'd5; wrAddr(1'b1, 7'h7C);
    frame();
    check("R6 invalid codec blocks", {txTag1, txBusy1}, 2'b01);
    codecSel = 3'd1;
    frame();
    check("R6 sent after fix", {txTag1, txCodec}, {1'b1, 2'd1});

    // receive
    rxTag1 = 1; rxTag2 = 1; rxSlot1In = 20'h26000; rxSlot2In = 20'h12340;
    frame();
    rxTag1 = 0; rxTag2 = 0;
    check("R7 valid flags", {rxValid1, rxValid2}, 2'b11);
    check("R7 returned index", rxIdx, 7'h26);
    check("R7 returned value", rxVal, 16'h1234);
    hostRdAck1 = 1; cyc(); hostRdAck1 = 0;
    check("R8 read clears own flag", {rxValid1, rxValid2}, 2'b01);
    hostRdAck2 = 1; rxTag2 = 1; rxSlot2In = 20'h0BEE0;
    frame();
    hostRdAck2 = 0; rxTag2 = 0;
    check("R8 capture wins", {rxValid2, rxVal}, {1'b1, 16'h0BEE});
    hostRdAck2 = 1; cyc(); hostRdAck2 = 0;
    check("R8 cleared", rxValid2, 0);

    // link reset request
    linkResetReq = 1; cyc(); linkResetReq = 0;
    check("R9 reset request", {linkRstN, linkReady}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule